// File: doc/BRIEF.md
# Multi-Format TFT Pixel Output Engine

This block drives a bare TFT panel that has no controller of its own. It runs the panel's raster: a line of active pixels followed by horizontal blanking, repeated for every line and then followed by a stretch of blank lines. While the raster is in the active area, it pulls packed 32-bit words from an on-chip image FIFO and unpacks them into 18-bit RGB666 pixels. A data-enable strobe marks the active area. The FIFO must be show-ahead: the head word is visible whenever the FIFO is not empty, and the engine pops it with a read strobe in the same cycle.

There are four pixel formats. Two are direct colour: RGB666 takes one word per pixel, and RGB565 takes two pixels per word and is widened to 18 bits. The other two use an 8-bit index, four indices per word, and look the index up in a 256-entry palette RAM. One of these uses the index as is. The other first adds a programmable offset to it, modulo 256. The format and the offset are captured on the first clock of each frame and held for the whole frame.

If the FIFO is empty when a pixel needs a new word, the engine does not stall. It blanks the rest of that line to black, keeps data enable running and sets a sticky underflow flag. The next line starts with a fresh check of the FIFO.

Top module: `tft_pixel_engine`

## Requirements
- R1: Each line has H_ACTIVE data-enable clocks followed by H_BLANK clocks without data enable. Each frame has V_ACTIVE such lines followed by V_BLANK lines that are entirely blank. A raster position is scanned at one clock and appears on `pix_de`/`pix_data` two clocks later. The first position after reset is scanned in the first clock in which `rst_n` is high.
- R2: `pix_data` is zero whenever `pix_de` is low.
- R3: Format code 00 (RGB666) pops one FIFO word per pixel, and the pixel is bits [17:0] of that word.
- R4: Format code 01 (RGB565) pops one word per two pixels, and the first pixel comes from bits [15:0]. Output is {R,G,B} with R in [17:12], G in [11:6] and B in [5:0]. The 5-bit red and blue fields gain a low bit that copies their own top bit.
- R5: Format code 10 (indexed) pops one word per four pixels and takes the index bytes from least significant to most significant. The pixel is the palette entry at that index.
- R6: Format code 11 (indexed with offset) unpacks words as in format 10. The pixel is the palette entry at (index + `pal_base`) mod 256.
- R7: `fmt_sel` and `pal_base` are sampled on the first clock of a frame. Changes to them later in the frame have no effect until the next frame starts.
- R8: A palette write with `pal_we` high stores `pal_wdata` at `pal_waddr`. Both indexed formats read colours from that store.
- R9: If the FIFO is empty when a line's first pixel is scanned, the whole line is black with data enable still high. No word is popped during that line, and `underflow` is set.
- R10: If the FIFO is empty when a later pixel of a line needs a new word, that pixel and the rest of the line are black. No further word is popped during the line, and `underflow` is set.
- R11: `fifo_rd` is never high while `fifo_empty` is high, and never high while `rst_n` is low.
- R12: Reset clears `pix_de`, `pix_data` and `underflow`. Once set, `underflow` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Pixel format code, sampled at frame start |
| pal_base | input | 8 | Index offset for format 11, sampled at frame start |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 8 | Palette write address |
| pal_wdata | input | 18 | Palette write colour (RGB666) |
| fifo_empty | input | 1 | Image FIFO has no word |
| fifo_rdata | input | 32 | Head word of the image FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the head word at this clock edge |
| pix_de | output | 1 | Panel data enable |
| pix_data | output | 18 | RGB666 pixel to the panel |
| underflow | output | 1 | Sticky FIFO underflow flag |

## Verification
Some properties hold on every cycle and are checked by assertions. A pop is never issued against an empty FIFO. Blank cycles carry zero data. Data enable follows the raster with a fixed two-clock delay. The underflow flag rises only after an empty FIFO was seen and never falls. A packed format never pops on two consecutive clocks.

Other behaviour can only be shown by the bench scenarios, which run frames in every format and compare the output pixel by pixel: the unpacking order, the RGB565 widening, the palette offset wrapping past 255, a format change in mid-frame being ignored, and the difference in blackout between a miss at the start of a line and a miss in the middle of one.

// File: rtl/tft_px_pkg.sv
// Shared types and helpers for the TFT pixel output engine.
// Assumes 32-bit FIFO words and 18-bit RGB666 panel pixels.
package tft_px_pkg;

    localparam int WORD_W = 32;
    localparam int PIX_W  = 18;
    localparam int IDX_W  = 8;
    localparam int PAL_DEPTH = 1 << IDX_W;

    typedef enum logic [1:0] {
        FMT_RGB18  = 2'b00,
        FMT_RGB16  = 2'b01,
        FMT_IDX8   = 2'b10,
        FMT_IDXOFS = 2'b11
    } pix_fmt_e;

    // Widens RGB565 to RGB666 by copying the top bit of red and blue downward.
    function automatic logic [PIX_W-1:0] widen_565(input logic [15:0] c);
        return {c[15:11], c[15], c[10:5], c[4:0], c[4]};
    endfunction

endpackage

// File: rtl/tft_scan_timer.sv
// Raster counter for the panel: active pixels then blanking per line,
// active lines then blank lines per frame. Assumes H_ACT is a multiple of 4.
module tft_scan_timer #(
    parameter int H_ACT   = 320,
    parameter int H_BLANK = 68,
    parameter int V_ACT   = 240,
    parameter int V_BLANK = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       active,
    output logic       line_first,
    output logic       frame_start,
    output logic [1:0] lane_pos
);
    localparam int H_TOT = H_ACT + H_BLANK;
    localparam int V_TOT = V_ACT + V_BLANK;
    localparam int HW = $clog2(H_TOT);
    localparam int VW = $clog2(V_TOT);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    // Advance the horizontal and vertical position every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == HW'(H_TOT - 1)) begin
            hcnt <= '0;
            vcnt <= (vcnt == VW'(V_TOT - 1)) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Decode the area flags from the position.
    always_comb begin
        active      = (hcnt < HW'(H_ACT)) && (vcnt < VW'(V_ACT));
        line_first  = active && (hcnt == '0);
        frame_start = (hcnt == '0) && (vcnt == '0);
        lane_pos    = hcnt[1:0];
    end

endmodule

// File: rtl/tft_pixel_unpack.sv
// Fetch and unpack stage. Decides when to pop the show-ahead FIFO for the
// current format, picks the pixel lane out of the word, tracks whether the
// line is still fed, and registers the result into stage 1.
module tft_pixel_unpack
    import tft_px_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              line_first,
    input  logic [1:0]        lane_pos,
    input  pix_fmt_e          fmt,
    input  logic [IDX_W-1:0]  pal_ofs,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd,
    output logic [IDX_W-1:0]  pal_addr,
    output logic              s1_de,
    output logic              s1_ok,
    output logic              s1_use_pal,
    output logic [PIX_W-1:0]  s1_direct,
    output logic              underflow
);
    localparam int LANES = WORD_W / IDX_W;

    logic [WORD_W-1:0] word_q;
    logic              line_ok_q;
    logic [1:0]        lane;
    logic              fetch, go, ok;
    logic [WORD_W-1:0] word;
    logic [15:0]       half;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  lane_byte [LANES];
    logic [PIX_W-1:0]  direct;

    // Split the current word into its byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = word[g*IDX_W +: IDX_W];
    end

    // Work out the lane, the fetch point and the pixel value for this clock.
    always_comb begin
        unique case (fmt)
            FMT_RGB18: lane = 2'd0;
            FMT_RGB16: lane = {1'b0, lane_pos[0]};
            default:   lane = lane_pos;
        endcase
        fetch   = active && (lane == 2'd0);
        go      = line_first || line_ok_q;
        ok      = active && go && !(fetch && fifo_empty);
        fifo_rd = rst_n && ok && fetch;
        word    = fetch ? fifo_rdata : word_q;
        half    = lane[0] ? word[31:16] : word[15:0];
        idx     = lane_byte[lane];
        pal_addr = (fmt == FMT_IDXOFS) ? idx + pal_ofs : idx;
        direct  = (fmt == FMT_RGB18) ? word[PIX_W-1:0] : widen_565(half);
    end

    // Hold the fetched word, line state, underflow flag and stage-1 outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q     <= '0;
            line_ok_q  <= 1'b0;
            underflow  <= 1'b0;
            s1_de      <= 1'b0;
            s1_ok      <= 1'b0;
            s1_use_pal <= 1'b0;
            s1_direct  <= '0;
        end else begin
            if (fifo_rd)
                word_q <= fifo_rdata;
            if (active)
                line_ok_q <= ok;
            if (fetch && go && fifo_empty)
                underflow <= 1'b1;
            s1_de      <= active;
            s1_ok      <= ok;
            s1_use_pal <= fmt[1];
            s1_direct  <= direct;
        end
    end

endmodule

// File: rtl/tft_palette_ram.sv
// Colour lookup store: one write port and one registered read port.
// No reset; contents are undefined until written.
module tft_palette_ram #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store written colours and read the addressed entry once per clock.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tft_pixel_engine.sv
// Top of the TFT pixel output engine. Latches the format and the palette
// offset at frame start, runs the scan timer, unpacks FIFO words and drives
// the registered panel outputs. Latency from scan to pins is two clocks.
module tft_pixel_engine
    import tft_px_pkg::*;
#(
    parameter int H_ACTIVE = 320,
    parameter int H_BLANK  = 68,
    parameter int V_ACTIVE = 240,
    parameter int V_BLANK  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic [IDX_W-1:0]  pal_base,
    input  logic              pal_we,
    input  logic [IDX_W-1:0]  pal_waddr,
    input  logic [PIX_W-1:0]  pal_wdata,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd,
    output logic              pix_de,
    output logic [PIX_W-1:0]  pix_data,
    output logic              underflow
);
    logic             scan_active, line_first, frame_start;
    logic [1:0]       lane_pos;
    pix_fmt_e         fmt_q, fmt_use;
    logic [IDX_W-1:0] base_q, base_use;
    logic [IDX_W-1:0] pal_raddr;
    logic [PIX_W-1:0] pal_rdata;
    logic             s1_de, s1_ok, s1_use_pal;
    logic [PIX_W-1:0] s1_direct;

    tft_scan_timer #(
        .H_ACT(H_ACTIVE), .H_BLANK(H_BLANK),
        .V_ACT(V_ACTIVE), .V_BLANK(V_BLANK)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .active(scan_active), .line_first(line_first),
        .frame_start(frame_start), .lane_pos(lane_pos)
    );

    // Use the live selection on the first clock of a frame, the held one after.
    always_comb begin
        fmt_use  = frame_start ? pix_fmt_e'(fmt_sel) : fmt_q;
        base_use = frame_start ? pal_base : base_q;
    end

    // Hold the format and offset for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_RGB18;
            base_q <= '0;
        end else if (frame_start) begin
            fmt_q  <= pix_fmt_e'(fmt_sel);
            base_q <= pal_base;
        end
    end

    tft_pixel_unpack u_unpack (
        .clk(clk), .rst_n(rst_n),
        .active(scan_active), .line_first(line_first), .lane_pos(lane_pos),
        .fmt(fmt_use), .pal_ofs(base_use),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .pal_addr(pal_raddr),
        .s1_de(s1_de), .s1_ok(s1_ok), .s1_use_pal(s1_use_pal),
        .s1_direct(s1_direct), .underflow(underflow)
    );

    tft_palette_ram #(.AW(IDX_W), .DW(PIX_W)) u_pal (
        .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
        .raddr(pal_raddr), .rdata(pal_rdata)
    );

    // Stage 2: choose direct or palette colour, black for a starved pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_de   <= 1'b0;
            pix_data <= '0;
        end else begin
            pix_de   <= s1_de;
            pix_data <= !s1_ok ? '0 : (s1_use_pal ? pal_rdata : s1_direct);
        end
    end

endmodule

// File: rtl/tft_pixel_engine_chk.sv
// Cycle properties of the pixel engine, attached to every instance by bind.
module tft_pixel_engine_chk
    import tft_px_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_rd,
    input logic             fifo_empty,
    input logic             pix_de,
    input logic [PIX_W-1:0] pix_data,
    input logic             underflow,
    input logic             scan_active,
    input pix_fmt_e         fmt_use
);
    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);  // R11

    AST_BLANK_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |-> (pix_data == '0));  // R2

    AST_DE_TRACKS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scan_active) && $past(rst_n)) |=> pix_de);  // R1

    AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);  // R12

    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(fifo_empty));  // R9

    AST_PACKED_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fmt_use != FMT_RGB18) |=> !fifo_rd);  // R4

endmodule

bind tft_pixel_engine tft_pixel_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
    .pix_de(pix_de), .pix_data(pix_data), .underflow(underflow),
    .scan_active(scan_active), .fmt_use(fmt_use)
);

// File: tb/sim_tft_pixel_engine.sv
// Bench: behavioural FIFO and raster model compared with the engine every clock.
module sim_tft_pixel_engine;
    localparam int HA = 8, HB = 4, VA = 3, VB = 2;
    localparam int FRAME = (HA + HB) * (VA + VB);
    localparam int NFRAMES = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [7:0]  pal_base = 8'd0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_waddr = 8'd0;
    logic [17:0] pal_wdata = 18'd0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rdata = 32'd0;
    logic        fifo_rd, pix_de, underflow;
    logic [17:0] pix_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    tft_pixel_engine #(.H_ACTIVE(HA), .H_BLANK(HB), .V_ACTIVE(VA), .V_BLANK(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .pal_base(pal_base),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .pix_de(pix_de), .pix_data(pix_data), .underflow(underflow)
    );

    always #4 clk = ~clk;

    // Model state
    logic [31:0] q[$];
    int pal[256];
    int hc = 0, vc = 0, mfmt = 0, mbase = 0;
    logic [31:0] mw = 0;
    bit mok = 0, muf = 0, mlost_start = 0, pend_pop = 0;
    bit p1_de = 0, p2_de = 0;
    int p1_data = 0, p2_data = 0;
    string p1_tag = "R2", p2_tag = "R2";
    int unsigned seed = 32'h1234_5678;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int widen(int h);
        int r, g, b;
        r = (h >> 11) & 31; g = (h >> 5) & 63; b = h & 31;
        return ((((r << 1) | (r >> 4)) << 12) | (g << 6) | ((b << 1) | (b >> 4)));
    endfunction

    task automatic push_words(int n);
        for (int i = 0; i < n; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            q.push_back(seed);
        end
    endtask

    // Frame plan: formats, offsets and word counts; frame 4 starves on purpose (R9, R10).
    task automatic start_frame(int f);
        case (f)
            0: begin fmt_sel = 2'b00; push_words(HA * VA); end
            1: begin fmt_sel = 2'b01; push_words(HA * VA / 2); end
            2: begin fmt_sel = 2'b10; push_words(HA * VA / 4); end
            3: begin fmt_sel = 2'b11; pal_base = 8'h10; push_words(HA * VA / 4); end
            4: begin fmt_sel = 2'b01; push_words(HA / 2 + HA / 4); end
            5: begin fmt_sel = 2'b11; pal_base = 8'hF0; push_words(HA * VA / 4); end
            default: begin fmt_sel = 2'b00; push_words(HA * VA); end
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : main
        // Load the palette while reset is held (R8).
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pal[i] = (i * 2731 + 77) & 32'h3FFFF;
            pal_we = 1'b1; pal_waddr = 8'(i); pal_wdata = 18'(pal[i]);
        end
        @(negedge clk);
        pal_we = 1'b0;
        #1;
        // Reset state (R12)
        chk("R12 reset de", int'(pix_de), 0);
        chk("R12 reset data", int'(pix_data), 0);
        chk("R12 reset underflow", int'(underflow), 0);
        chk("R11 reset rd", int'(fifo_rd), 0);

        for (int c = 0; c < NFRAMES * FRAME; c++) begin
            bit active, fetch, go, ok, exp_rd, nuf, e_de;
            int lane, e_data, colour, idx;
            logic [31:0] w;
            string tag;
            @(negedge clk);
            rst_n = 1'b1;
            if (pend_pop) begin void'(q.pop_front()); pend_pop = 0; end
            if (c % FRAME == 0) start_frame(c / FRAME);
            if (c / FRAME == 3 && c % FRAME == 20) begin fmt_sel = 2'b00; pal_base = 8'h55; end
            fifo_empty = (q.size() == 0);
            fifo_rdata = fifo_empty ? 32'd0 : q[0];
            #1;
            // Reference step for this raster position.
            if (hc == 0 && vc == 0) begin mfmt = int'(fmt_sel); mbase = int'(pal_base); end
            active = (hc < HA) && (vc < VA);
            exp_rd = 0; nuf = 0; e_de = active; e_data = 0; tag = "R2";
            if (active) begin
                lane = (mfmt == 0) ? 0 : (mfmt == 1) ? (hc % 2) : (hc % 4);
                fetch = (lane == 0);
                go = (hc == 0) || mok;
                ok = go && !(fetch && fifo_empty);
                exp_rd = ok && fetch;
                nuf = fetch && go && fifo_empty;
                w = fetch ? fifo_rdata : mw;
                case (mfmt)
                    0: begin colour = int'(w[17:0]); tag = "R3"; end
                    1: begin colour = widen(int'((w >> (16 * lane)) & 32'hFFFF)); tag = "R4"; end
                    2: begin idx = int'((w >> (8 * lane)) & 32'hFF); colour = pal[idx]; tag = "R5 R8"; end
                    default: begin
                        idx = int'(((w >> (8 * lane)) + 32'(mbase)) & 32'hFF);
                        colour = pal[idx];
                        tag = (c / FRAME == 3 && c % FRAME >= 20) ? "R7 R6 R8" : "R6 R8";
                    end
                endcase
                if (hc == 0) mlost_start = !ok;
                if (!ok) tag = mlost_start ? "R9" : "R10";
                e_data = ok ? colour : 0;
                if (exp_rd) mw = w;
                mok = ok;
            end
            chk("R11 fifo_rd", int'(fifo_rd), int'(exp_rd));
            chk("R1 pix_de", int'(pix_de), int'(p2_de));
            chk(p2_tag, int'(pix_data), p2_data);
            chk("R12 underflow", int'(underflow), int'(muf));
            p2_de = p1_de; p2_data = p1_data; p2_tag = p1_tag;
            p1_de = e_de; p1_data = e_data; p1_tag = tag;
            pend_pop = exp_rd;
            muf = muf | nuf;
            if (hc == HA + HB - 1) begin
                hc = 0;
                vc = (vc == VA + VB - 1) ? 0 : vc + 1;
            end else begin
                hc = hc + 1;
            end
        end
        // Underflow must still be latched after later, fully fed frames (R12).
        chk("R12 underflow held", int'(underflow), 1);
        finish_run();
    end

endmodule